// File: doc/BRIEF.md
# Prioritized Reset State Controller

This block sits in the always-on domain and runs from the slow clock. It gathers five reset causes and turns them into three active-low outputs: a processor reset, a peripheral reset and a drive for the external reset pad. The five causes are the chip-level power-on release, a wake from the backup domain, a watchdog fault, a software reset command and a low level on the external reset pin. A fixed priority settles simultaneous requests. Per-state rules decide whether a request that arrives during a reset pre-empts it or is dropped.

Each reset lasts a timed interval. For most causes the interval is a power-of-two number of slow-clock cycles, selected by a length field. A watchdog reset can be limited to the processor alone, and then lasts a short fixed start-up interval. A three-bit cause code is loaded when each reset state is entered. It then holds, so software can read it once the processor runs again.

Top module: `rst_state_ctrl`

## Requirements
- R1: While rst_ni is low, and for 8 cycles after it rises (default general length 2), the controller is in the general reset: all three outputs are low and rst_type_o = 0. On the next cycle all outputs are high.
- R2: Requests that arrive together while idle are ranked backup, then watchdog, then software, then pin. The cause codes are backup 1, watchdog 2, software 3 and pin 4.
- R3: A reset other than a processor-only watchdog reset holds its outputs low for 2^(len+1) cycles, where len is ext_len_i sampled on the entry edge. A later change of ext_len_i does not alter a reset that is already running.
- R4: A watchdog reset with wdt_proc_only_i = 0 drives all three outputs low and records code 2. The peripheral or pad reset is never low while the processor reset is high.
- R5: A watchdog reset with wdt_proc_only_i = 1 drives only proc_rst_no low, for 2 cycles, and records code 2.
- R6: A watchdog fault during a software reset moves the controller to the watchdog reset on the next edge. The code becomes 2 and the interval restarts.
- R7: A low level on the pin during a software reset is ignored. No pin reset follows once the pin has returned high.
- R8: A watchdog fault during a pin reset is ignored.
- R9: A software command or a low pin during a watchdog reset is ignored.
- R10: The pin passes through a two-flop synchronizer. A pin driven low while idle starts the pin reset on the third edge after the low level first appears.
- R11: A backup wake during a watchdog, software or pin reset pre-empts it: the code becomes 1 and the interval restarts.
- R12: rst_type_o keeps its value while idle, until the next reset state is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow clock |
| rst_ni | input | 1 | Asynchronous chip-level (general) reset, active low |
| backup_wake_i | input | 1 | Backup-domain wake request |
| wdt_fault_i | input | 1 | Watchdog fault request |
| sw_rst_i | input | 1 | Software reset command |
| ext_rst_ni | input | 1 | External reset pin level, asynchronous, active low |
| ext_len_i | input | LEN_W | Reset length exponent; interval = 2^(len+1) |
| wdt_proc_only_i | input | 1 | Watchdog resets the processor only |
| proc_rst_no | output | 1 | Processor reset, active low |
| periph_rst_no | output | 1 | Peripheral reset, active low |
| ext_rst_no | output | 1 | External pad reset drive, active low |
| rst_type_o | output | 3 | Cause code of the latest reset |

## Verification
The assertions assume that the request inputs are synchronous to the slow clock and stay stable around each edge. They also assume that ext_len_i and wdt_proc_only_i are valid on the cycle a request is taken. The stimulus changes every input two nanoseconds after a rising edge. The pin is released before any reset it overlaps comes to an end, so the pin reset's own pad drive never has to be told apart from a second request. Fault and command pulses last one cycle, so a request that a state dropped is not still pending when that state returns to idle.

// File: rtl/rst_ctrl_pkg.sv
package rst_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GEN,
    ST_BKP,
    ST_WDT,
    ST_SW,
    ST_USR
  } rst_state_e;

  localparam logic [2:0] TY_GEN = 3'd0;
  localparam logic [2:0] TY_BKP = 3'd1;
  localparam logic [2:0] TY_WDT = 3'd2;
  localparam logic [2:0] TY_SW  = 3'd3;
  localparam logic [2:0] TY_USR = 3'd4;

  function automatic logic [2:0] type_of(rst_state_e s);
    case (s)
      ST_BKP:  return TY_BKP;
      ST_WDT:  return TY_WDT;
      ST_SW:   return TY_SW;
      ST_USR:  return TY_USR;
      default: return TY_GEN;
    endcase
  endfunction
endpackage

// File: rtl/rst_pin_sync.sv
module rst_pin_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic sync_o
);
  logic [1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= 2'b11;
    else         ff_q <= {ff_q[0], pin_i};
  end

  assign sync_o = ff_q[1];

  p_sync_delay_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sync_o) |-> !$past(pin_i, 2));
endmodule

// File: rtl/rst_pulse_timer.sv
module rst_pulse_timer #(
  parameter int CNT_W   = 17,
  parameter int RST_VAL = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= CNT_W'(RST_VAL);
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  p_cnt_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/rst_arbiter.sv
module rst_arbiter
  import rst_ctrl_pkg::*;
#(
  parameter int LEN_W       = 4,
  parameter int CNT_W       = 17,
  parameter int STARTUP_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             backup_wake_i,
  input  logic             wdt_fault_i,
  input  logic             sw_rst_i,
  input  logic             pin_low_i,
  input  logic [LEN_W-1:0] ext_len_i,
  input  logic             wdt_proc_only_i,
  input  logic             tmr_zero_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output rst_state_e       state_o,
  output logic [2:0]       type_o,
  output logic             wdt_only_o
);
  localparam logic [CNT_W-1:0] STARTUP_LOAD = CNT_W'(STARTUP_CYC - 1);

  rst_state_e state_q, state_d;
  logic [2:0] type_q, type_d;
  logic       only_q, only_d;
  logic [LEN_W:0]   shamt;
  logic [CNT_W-1:0] ext_load;

  always_comb begin
    shamt    = {1'b0, ext_len_i} + 1'b1;
    ext_load = ({{(CNT_W-1){1'b0}}, 1'b1} << shamt) - 1'b1;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (backup_wake_i)    state_d = ST_BKP;
        else if (wdt_fault_i) state_d = ST_WDT;
        else if (sw_rst_i)    state_d = ST_SW;
        else if (pin_low_i)   state_d = ST_USR;
      end
      ST_GEN, ST_BKP: if (tmr_zero_i) state_d = ST_IDLE;
      ST_WDT: begin
        // processor reset is active: software and pin requests are dropped
        if (backup_wake_i)   state_d = ST_BKP;
        else if (tmr_zero_i) state_d = ST_IDLE;
      end
      ST_SW: begin
        if (backup_wake_i)    state_d = ST_BKP;
        else if (wdt_fault_i) state_d = ST_WDT;
        else if (tmr_zero_i)  state_d = ST_IDLE;
      end
      ST_USR: begin
        // watchdog held in reset by the processor reset
        if (backup_wake_i)   state_d = ST_BKP;
        else if (tmr_zero_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    load_o     = 1'b0;
    load_val_o = ext_load;
    type_d     = type_q;
    only_d     = only_q;
    if (state_d != state_q && state_d != ST_IDLE) begin
      load_o = 1'b1;
      type_d = type_of(state_d);
      only_d = (state_d == ST_WDT) && wdt_proc_only_i;
      if (only_d) load_val_o = STARTUP_LOAD;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_GEN;
      type_q  <= TY_GEN;
      only_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      type_q  <= type_d;
      only_q  <= only_d;
    end
  end

  assign state_o    = state_q;
  assign type_o     = type_q;
  assign wdt_only_o = only_q;

  p_wdt_preempts_sw_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SW && wdt_fault_i && !backup_wake_i) |=> (state_q == ST_WDT && type_o == TY_WDT));
  p_usr_ignores_wdt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_USR && !backup_wake_i && !tmr_zero_i) |=> state_q == ST_USR);
  p_wdt_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WDT && !backup_wake_i && !tmr_zero_i) |=> state_q == ST_WDT);
  p_backup_preempt_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_WDT || state_q == ST_SW || state_q == ST_USR) && backup_wake_i)
      |=> (state_q == ST_BKP && type_o == TY_BKP));
  p_type_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && $past(state_q) == ST_IDLE) |-> $stable(type_o));
endmodule

// File: rtl/rst_state_ctrl.sv
module rst_state_ctrl
  import rst_ctrl_pkg::*;
#(
  parameter int LEN_W       = 4,
  parameter int STARTUP_CYC = 2,
  parameter int GEN_LEN     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             backup_wake_i,
  input  logic             wdt_fault_i,
  input  logic             sw_rst_i,
  input  logic             ext_rst_ni,
  input  logic [LEN_W-1:0] ext_len_i,
  input  logic             wdt_proc_only_i,
  output logic             proc_rst_no,
  output logic             periph_rst_no,
  output logic             ext_rst_no,
  output logic [2:0]       rst_type_o
);
  localparam int CNT_W    = (1 << LEN_W) + 1;
  localparam int GEN_LOAD = (1 << (GEN_LEN + 1)) - 1;

  logic             pin_sync;
  logic             tmr_zero;
  logic             load;
  logic [CNT_W-1:0] load_val;
  rst_state_e       state;
  logic             wdt_only;
  logic             wide_act;

  rst_pin_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (ext_rst_ni),
    .sync_o (pin_sync)
  );

  rst_pulse_timer #(.CNT_W(CNT_W), .RST_VAL(GEN_LOAD)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .zero_o     (tmr_zero)
  );

  rst_arbiter #(.LEN_W(LEN_W), .CNT_W(CNT_W), .STARTUP_CYC(STARTUP_CYC)) u_arb (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .backup_wake_i   (backup_wake_i),
    .wdt_fault_i     (wdt_fault_i),
    .sw_rst_i        (sw_rst_i),
    .pin_low_i       (!pin_sync),
    .ext_len_i       (ext_len_i),
    .wdt_proc_only_i (wdt_proc_only_i),
    .tmr_zero_i      (tmr_zero),
    .load_o          (load),
    .load_val_o      (load_val),
    .state_o         (state),
    .type_o          (rst_type_o),
    .wdt_only_o      (wdt_only)
  );

  assign wide_act      = (state != ST_IDLE) && !(state == ST_WDT && wdt_only);
  assign proc_rst_no   = (state == ST_IDLE);
  assign periph_rst_no = !wide_act;
  assign ext_rst_no    = !wide_act;

  p_proc_covers_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!periph_rst_no || !ext_rst_no) |-> !proc_rst_no);
endmodule

// File: tb/sim_rst_state_ctrl.sv
module sim_rst_state_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       backup, wdt, sw, pin, only;
  logic [3:0] len;
  logic       proc_n, periph_n, ext_n;
  logic [2:0] rtype;

  always #4 clk = ~clk;

  rst_state_ctrl u0 (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .backup_wake_i   (backup),
    .wdt_fault_i     (wdt),
    .sw_rst_i        (sw),
    .ext_rst_ni      (pin),
    .ext_len_i       (len),
    .wdt_proc_only_i (only),
    .proc_rst_no     (proc_n),
    .periph_rst_no   (periph_n),
    .ext_rst_no      (ext_n),
    .rst_type_o      (rtype)
  );

  typedef struct {
    int unsigned at;
    logic [5:0]  exp;
    string       tag;
  } item_t;

  item_t       sbq[$];
  int          checks = 0;
  int          fails  = 0;
  int unsigned cyc    = 0;

  localparam logic [2:0] LOW3 = 3'b000;
  localparam logic [2:0] PRC  = 3'b011;
  localparam logic [2:0] HIGH = 3'b111;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(int unsigned off, logic [2:0] rs, logic [2:0] ty, string tag);
    item_t it;
    it.at  = cyc + off;
    it.exp = {rs, ty};
    it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic expect_span(int unsigned a, int unsigned b, logic [2:0] rs, logic [2:0] ty, string tag);
    for (int unsigned i = a; i <= b; i++) expect_at(i, rs, ty, tag);
  endtask

  task automatic tick(int n);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  // monitor: pops every item due this cycle
  always @(negedge clk) begin
    logic [5:0] got;
    got = {proc_n, periph_n, ext_n, rtype};
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].at == cyc) begin
        checks++;
        if (got !== sbq[i].exp) begin
          fails++;
          $display("FAIL %s cyc=%0d actual=%b expected=%b", sbq[i].tag, cyc, got, sbq[i].exp);
        end
        sbq.delete(i);
      end
    end
  end

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    rst_n = 1'b0; backup = 0; wdt = 0; sw = 0; pin = 1; only = 0; len = 4'd1;
    tick(3);
    // R1: general reset after release
    rst_n = 1'b1;
    expect_span(0, 7, LOW3, 3'd0, "R1");
    expect_at(8, HIGH, 3'd0, "R1");
    tick(10);

    // R4: full watchdog reset
    wdt = 1;
    expect_span(1, 4, LOW3, 3'd2, "R4");
    expect_span(5, 6, HIGH, 3'd2, "R12");
    tick(1); wdt = 0; tick(7);

    // R5: processor-only watchdog
    only = 1; wdt = 1;
    expect_span(1, 2, PRC, 3'd2, "R5");
    expect_at(3, HIGH, 3'd2, "R5");
    tick(1); wdt = 0; only = 0; tick(5);

    // R3: length 2 -> 8 cycles, change mid-reset has no effect
    len = 4'd2; sw = 1;
    expect_span(1, 8, LOW3, 3'd3, "R3");
    expect_at(9, HIGH, 3'd3, "R3");
    tick(1); sw = 0; tick(1); len = 4'd0; tick(10);
    // R3: length 0 -> 2 cycles
    sw = 1;
    expect_span(1, 2, LOW3, 3'd3, "R3");
    expect_at(3, HIGH, 3'd3, "R3");
    tick(1); sw = 0; len = 4'd1; tick(4);

    // R10: pin synchronizer latency
    pin = 0;
    expect_at(2, HIGH, 3'd3, "R10");
    expect_span(3, 6, LOW3, 3'd4, "R10");
    expect_at(7, HIGH, 3'd4, "R10");
    tick(2); pin = 1; tick(8);

    // R2: backup wins over all
    backup = 1; wdt = 1; sw = 1; pin = 0;
    expect_span(1, 4, LOW3, 3'd1, "R2");
    expect_at(5, HIGH, 3'd1, "R2");
    tick(1); backup = 0; wdt = 0; sw = 0; pin = 1; tick(6);
    // R2: watchdog over software
    wdt = 1; sw = 1;
    expect_span(1, 4, LOW3, 3'd2, "R2");
    expect_at(5, HIGH, 3'd2, "R2");
    tick(1); wdt = 0; sw = 0; tick(6);
    // R2 / R7: software over pin, pin ignored during software reset
    sw = 1; pin = 0;
    expect_span(1, 4, LOW3, 3'd3, "R2");
    expect_span(5, 8, HIGH, 3'd3, "R7");
    tick(1); sw = 0; tick(1); pin = 1; tick(8);

    // R6: watchdog pre-empts software reset
    sw = 1;
    expect_span(1, 2, LOW3, 3'd3, "R6");
    tick(1); sw = 0; tick(1); wdt = 1;
    expect_span(1, 4, LOW3, 3'd2, "R6");
    expect_at(5, HIGH, 3'd2, "R6");
    tick(1); wdt = 0; tick(6);

    // R8: watchdog ignored during pin reset
    pin = 0;
    expect_span(3, 6, LOW3, 3'd4, "R8");
    expect_span(7, 8, HIGH, 3'd4, "R8");
    tick(2); pin = 1; tick(2); wdt = 1; tick(1); wdt = 0; tick(5);

    // R9: software and pin ignored during watchdog reset
    wdt = 1;
    expect_span(1, 4, LOW3, 3'd2, "R9");
    expect_span(5, 7, HIGH, 3'd2, "R9");
    tick(1); wdt = 0; pin = 0; tick(1); sw = 1; tick(1); sw = 0; pin = 1; tick(6);

    // R11: backup pre-empts software reset
    sw = 1;
    tick(1); sw = 0; tick(1); backup = 1;
    expect_span(1, 4, LOW3, 3'd1, "R11");
    expect_at(5, HIGH, 3'd1, "R11");
    tick(1); backup = 0; tick(6);

    tick(2);
    if (sbq.size() != 0) begin
      fails++;
      $display("FAIL scoreboard actual=%0d expected=0 pending items", sbq.size());
    end
    report();
  end
endmodule